// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block tracks control-flow divergence for one warp of a SIMT core. At a divergent branch the issue stage sends a split strobe with three things: the warp's current active-thread mask, one predicate bit per thread, and the PC of the split. The block records what it needs to bring the threads back together later, and returns the mask of threads that keep running first. When the matching join instruction issues, the join strobe pops the most recent record. The block then returns the mask to resume with and, if needed, a PC redirect for the fetch unit.

The stack is updated once per warp instruction. A split whose active threads all agree on the predicate pushes one entry marked uniform, and the active mask does not change. A split that really diverges pushes two entries. The lower entry holds the full current mask and is marked fall-through. The upper entry holds the predicate-taken threads and the split PC. The threads that did not take the predicate run first.

A later join pops the upper entry and sends fetch back to the stored PC with the taken threads. A second join pops the lower entry and restores the full mask without a redirect. Misuse never changes the stack and sets a sticky error flag. Misuse is a push with too little room, a pop of an empty stack, or both strobes in the same cycle.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset, next_mask_o is all ones, redirect_o is 0, redirect_pc_o is 0 and err_o is 0, and the stack is empty.
- R2: A split (split_i=1, join_i=0) is uniform when cur_mask_i & pred_i equals cur_mask_i or equals zero. It pushes one entry marked uniform that holds cur_mask_i. In the next cycle next_mask_o equals cur_mask_i.
- R3: A split that is not uniform pushes two entries. First comes a fall-through entry holding cur_mask_i. Then comes an entry holding cur_mask_i & pred_i and pc_i. In the next cycle next_mask_o equals cur_mask_i & ~pred_i.
- R4: A join (join_i=1, split_i=0) whose top entry is uniform pops it and sets next_mask_o to its mask, with redirect_o 0.
- R5: A join whose top entry is neither uniform nor fall-through pops it. In the next cycle it sets next_mask_o to its mask, raises redirect_o for exactly one cycle and puts the stored PC on redirect_pc_o.
- R6: A join whose top entry is fall-through pops it and sets next_mask_o to its mask, with redirect_o 0.
- R7: Entries pop in reverse order of their push, so nested splits unwind innermost first. The occupancy never exceeds DEPTH.
- R8: A split that needs more free entries than remain (one for uniform, two otherwise) leaves the stack and next_mask_o unchanged and sets err_o.
- R9: A join on an empty stack leaves next_mask_o unchanged, gives no redirect and sets err_o.
- R10: A split and a join strobed in the same cycle are both ignored and set err_o.
- R11: err_o stays 1 until reset. In any cycle after one with no successful join, redirect_o is 0 and redirect_pc_o is 0. With no strobe, next_mask_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_i | input | 1 | Split strobe, one cycle per split instruction |
| join_i | input | 1 | Join strobe, one cycle per join instruction |
| cur_mask_i | input | THREADS | Current active-thread mask of the warp |
| pred_i | input | THREADS | Per-thread predicate of the split |
| pc_i | input | PC_W | PC of the split instruction |
| next_mask_o | output | THREADS | Active mask to use after the last split or join |
| redirect_o | output | 1 | One-cycle request to fetch from redirect_pc_o |
| redirect_pc_o | output | PC_W | Redirect target, zero when redirect_o is 0 |
| err_o | output | 1 | Sticky misuse flag (overflow, underflow, both strobes) |

## Verification
Every pairing of a 4-bit current mask with a 4-bit predicate goes through a split followed by the joins that undo it. The cases include an empty mask, all-agree and all-disagree predicates, and partial overlaps. This sweep separates the uniform path from the divergent path. It also confirms that the taken mask, the redirect PC and the fall-through restore come back in that order. Nested divergent splits that fill the stack exactly show last-in first-out unwinding. Overflow by a uniform split, overflow by a divergent split with one free slot, underflow, and simultaneous strobes each end with further joins. Those joins show that no entry was added or lost.

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack #(
  parameter int THREADS = 4,
  parameter int DEPTH   = 8,
  parameter int PC_W    = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               split_i,
  input  logic               join_i,
  input  logic [THREADS-1:0] cur_mask_i,
  input  logic [THREADS-1:0] pred_i,
  input  logic [PC_W-1:0]    pc_i,
  output logic [THREADS-1:0] next_mask_o,
  output logic               redirect_o,
  output logic [PC_W-1:0]    redirect_pc_o,
  output logic               err_o
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [THREADS-1:0] mask_q [DEPTH];
  logic [PC_W-1:0]    pc_q   [DEPTH];
  logic [DEPTH-1:0]   uni_q, ft_q;
  logic [CW-1:0]      cnt_q;
  logic [THREADS-1:0] act_q;
  logic               redir_q, err_q;
  logic [PC_W-1:0]    rpc_q;

  logic [THREADS-1:0] taken;
  logic               uniform, do_split, do_join, no_room, empty;
  logic               ok_split, ok_join, bad;
  logic [AW-1:0]      top, wr0, wr1;

  assign taken    = cur_mask_i & pred_i;
  assign uniform  = (taken == cur_mask_i) || (taken == '0);
  assign do_split = split_i & ~join_i;
  assign do_join  = join_i & ~split_i;
  assign no_room  = (int'(cnt_q) + (uniform ? 1 : 2)) > DEPTH;
  assign empty    = (cnt_q == '0);
  assign ok_split = do_split & ~no_room;
  assign ok_join  = do_join & ~empty;
  assign bad      = (split_i & join_i) | (do_split & no_room) | (do_join & empty);
  assign top      = AW'(cnt_q - CW'(1));
  assign wr0      = AW'(cnt_q);
  assign wr1      = AW'(cnt_q + CW'(1));

  always_ff @(posedge clk) begin
    if (ok_split) begin
      mask_q[wr0] <= cur_mask_i;
      pc_q[wr0]   <= pc_i;
      uni_q[wr0]  <= uniform;
      ft_q[wr0]   <= 1'b1;
      if (!uniform) begin
        mask_q[wr1] <= taken;
        pc_q[wr1]   <= pc_i;
        uni_q[wr1]  <= 1'b0;
        ft_q[wr1]   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      act_q   <= '1;
      redir_q <= 1'b0;
      rpc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= err_q | bad;
      redir_q <= 1'b0;
      rpc_q   <= '0;
      if (ok_split) begin
        cnt_q <= cnt_q + (uniform ? CW'(1) : CW'(2));
        act_q <= uniform ? cur_mask_i : (cur_mask_i & ~pred_i);
      end else if (ok_join) begin
        cnt_q <= cnt_q - CW'(1);
        act_q <= mask_q[top];
        if (!uni_q[top] && !ft_q[top]) begin
          redir_q <= 1'b1;
          rpc_q   <= pc_q[top];
        end
      end
    end
  end

  assign next_mask_o   = act_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = rpc_q;
  assign err_o         = err_q;
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
  parameter int THREADS = 4,
  parameter int DEPTH   = 8,
  parameter int CW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               split_i,
  input logic               join_i,
  input logic [THREADS-1:0] cur_mask_i,
  input logic [THREADS-1:0] next_mask_o,
  input logic               redirect_o,
  input logic               err_o,
  input logic [CW-1:0]      cnt
);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R11
  redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(join_i && !split_i) |=> !redirect_o);

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_i && !join_i) |=> $stable(next_mask_o));

  // R7
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= DEPTH);

  // R9
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (join_i && !split_i && cnt == '0) |=> (err_o && !redirect_o && $stable(next_mask_o)));

  // R3
  split_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && !join_i && int'(cnt) + 2 <= DEPTH) |=> ((next_mask_o & ~$past(cur_mask_i)) == '0));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
  .THREADS(THREADS), .DEPTH(DEPTH), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .split_i(split_i), .join_i(join_i),
  .cur_mask_i(cur_mask_i), .next_mask_o(next_mask_o), .redirect_o(redirect_o),
  .err_o(err_o), .cnt(cnt_q)
);

// File: tb/tb_simt_reconv_stack.sv
module tb_simt_reconv_stack;
  localparam int T = 4;
  localparam int D = 4;
  localparam int P = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         split_i = 1'b0, join_i = 1'b0;
  logic [T-1:0] cur_mask_i = '0, pred_i = '0;
  logic [P-1:0] pc_i = '0;
  logic [T-1:0] next_mask_o;
  logic         redirect_o, err_o;
  logic [P-1:0] redirect_pc_o;

  int n_run = 0, n_fail = 0;

  simt_reconv_stack #(.THREADS(T), .DEPTH(D), .PC_W(P)) dut (
    .clk(clk), .rst_n(rst_n), .split_i(split_i), .join_i(join_i),
    .cur_mask_i(cur_mask_i), .pred_i(pred_i), .pc_i(pc_i),
    .next_mask_o(next_mask_o), .redirect_o(redirect_o),
    .redirect_pc_o(redirect_pc_o), .err_o(err_o));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    split_i = 1'b0; join_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic op(input logic s, input logic j, input logic [T-1:0] c,
                    input logic [T-1:0] p, input logic [P-1:0] pc);
    @(negedge clk);
    split_i = s; join_i = j; cur_mask_i = c; pred_i = p; pc_i = pc;
    @(negedge clk);
    split_i = 1'b0; join_i = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [T-1:0] m,
                            input logic r, input logic [P-1:0] rpc, input logic e);
    chk({req, " mask"}, 32'(next_mask_o), 32'(m));
    chk({req, " redirect"}, 32'(redirect_o), 32'(r));
    chk({req, " redirect_pc"}, 32'(redirect_pc_o), 32'(rpc));
    chk({req, " err"}, 32'(err_o), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    reset_dut();
    // R1: reset state
    expect_out("R1", 4'hF, 1'b0, '0, 1'b0);

    // R2..R6, R11: exhaustive split/join over mask and predicate
    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 16; p++) begin
        logic [T-1:0] cm, pm, tk;
        logic [P-1:0] pcv;
        logic uni;
        cm = T'(c); pm = T'(p); tk = cm & pm;
        uni = (tk == cm) || (tk == '0);
        pcv = P'((c << 12) | (p << 8) | 8'hA5);
        op(1'b1, 1'b0, cm, pm, pcv);
        if (uni) begin
          expect_out("R2 uniform split", cm, 1'b0, '0, 1'b0);
          op(1'b0, 1'b1, 4'h0, 4'h0, '0);
          expect_out("R4 uniform join", cm, 1'b0, '0, 1'b0);
        end else begin
          expect_out("R3 divergent split", cm & ~pm, 1'b0, '0, 1'b0);
          op(1'b0, 1'b1, 4'h0, 4'h0, '0);
          expect_out("R5 taken join", tk, 1'b1, pcv, 1'b0);
          @(negedge clk);
          expect_out("R11 redirect pulse ends", tk, 1'b0, '0, 1'b0);
          op(1'b0, 1'b1, 4'h0, 4'h0, '0);
          expect_out("R6 fall-through join", cm, 1'b0, '0, 1'b0);
        end
      end
    end

    // R7: nested divergence fills the stack exactly, then unwinds
    reset_dut();
    op(1'b1, 1'b0, 4'b1111, 4'b0011, 16'h1000);
    expect_out("R7 outer split", 4'b1100, 1'b0, '0, 1'b0);
    op(1'b1, 1'b0, 4'b1100, 4'b0100, 16'h2000);
    expect_out("R7 inner split", 4'b1000, 1'b0, '0, 1'b0);
    // R8: uniform split with a full stack
    op(1'b1, 1'b0, 4'b1000, 4'b1000, 16'h3000);
    expect_out("R8 overflow uniform", 4'b1000, 1'b0, '0, 1'b1);
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R7 inner taken", 4'b0100, 1'b1, 16'h2000, 1'b1);
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R7 inner restore", 4'b1100, 1'b0, '0, 1'b1);
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R7 outer taken", 4'b0011, 1'b1, 16'h1000, 1'b1);
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R7 outer restore", 4'b1111, 1'b0, '0, 1'b1);
    // R9: pop on empty
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R9 underflow", 4'b1111, 1'b0, '0, 1'b1);

    // R8: divergent split with only one free slot
    reset_dut();
    op(1'b1, 1'b0, 4'b0001, 4'b0001, 16'h0);
    op(1'b1, 1'b0, 4'b0010, 4'b0000, 16'h0);
    op(1'b1, 1'b0, 4'b0100, 4'b0100, 16'h0);
    expect_out("R8 three uniform", 4'b0100, 1'b0, '0, 1'b0);
    op(1'b1, 1'b0, 4'b1111, 4'b0101, 16'h4444);
    expect_out("R8 overflow divergent", 4'b0100, 1'b0, '0, 1'b1);
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R8 top intact", 4'b0100, 1'b0, '0, 1'b1);
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R8 next intact", 4'b0010, 1'b0, '0, 1'b1);

    // R10: split and join together are ignored
    reset_dut();
    op(1'b1, 1'b0, 4'b1111, 4'b0001, 16'h0007);
    expect_out("R10 setup", 4'b1110, 1'b0, '0, 1'b0);
    op(1'b1, 1'b1, 4'b0011, 4'b0001, 16'h0055);
    expect_out("R10 both strobes", 4'b1110, 1'b0, '0, 1'b1);
    @(negedge clk);
    chk("R11 err sticky", 32'(err_o), 32'd1);
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R10 stack unchanged", 4'b0001, 1'b1, 16'h0007, 1'b1);
    op(1'b0, 1'b1, 4'h0, 4'h0, '0);
    expect_out("R10 restore", 4'b1111, 1'b0, '0, 1'b1);

    // R1: reset clears the error
    reset_dut();
    expect_out("R1 after reset", 4'hF, 1'b0, '0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule